// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

A parameterised general-purpose I/O port, 32 pins wide by default, controlled through a simple register bus. The bus carries a valid strobe, a write flag, a word address and a data word. Reads are combinational from the address. Per pin, software sets the output level, the direction and the pull controls. A data-enable mask decides which pins a data write may change. Inputs are read back through a two-flop synchronizer.

Each pin can raise an interrupt. Three configuration bits select the trigger: a sense bit, a both-edge bit and an event-polarity bit. The supported triggers are rising edge, falling edge, either edge, high level and low level. Edge events stay latched in a raw status register until software clears them with a write-one-to-clear register. Level status simply follows the synchronized pin. A masked view is the raw status ANDed with the enable register. One registered interrupt line is the OR of the masked bits.

The pad drivers sit outside this block. The pull controls are plain output bits that go to the pad ring.

Top module: `gpio_sense_port`

## Requirements
- R1: A bit of 1 in the direction register (word address 2) drives the matching `pin_oe` bit to 1, meaning output; a bit of 0 means input. Reset value is all zeros.
- R2: A write to the data register (address 0) changes only those `pin_out` bits whose bit in the data-enable register (address 1) is 1. The other bits keep their value.
- R3: A read of address 0 returns the synchronized pin levels ANDed with the data-enable mask. A pin change is visible on the second rising edge after it occurs.
- R4: The pull-up register (address 3) is active-low: 0 turns the pull-up on, and its reset value is all ones. The pull-down register (address 4) is active-high with reset value 0. Both appear directly on `pull_up_n` and `pull_dn`.
- R5: The per-pin trigger is set by three registers: sense (address 5), both-edge (address 6) and event (address 7). With sense 0 the pin is in edge mode. Both-edge 1 then catches either edge whatever the event bit says; otherwise event 1 selects rising and event 0 selects falling. The raw status bit (read at address 9) is set on the third rising edge after the pin change. It stays set until cleared.
- R6: With sense 1 the pin is in level mode. Its raw status bit equals the synchronized level when event is 1, and the inverted level when event is 0, one cycle later. Writes to the clear register do not remove it while the level persists.
- R7: Writing 1 to a bit of the clear register (address 11, reads 0) clears that pin's edge status on the write edge. Writing 0 has no effect. A new edge in the same cycle wins over the clear.
- R8: The masked status (address 10) is raw status AND the interrupt-enable register (address 8). `irq` is the OR of the masked bits, registered one cycle.
- R9: After reset all outputs are 0 except `pull_up_n`, which is all ones. No status is set and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data levels |
| pin_oe | output | 32 | Direction, 1 = output |
| pull_up_n | output | 32 | Pull-up control, 0 = pull-up on |
| pull_dn | output | 32 | Pull-down control, 1 = pull-down on |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a data write under a partial enable mask; a design that ignored the mask would overwrite protected `pin_out` bits. It drives pins whose event bit selects falling while the pin rises, and sets a both-edge pin whose event bit is 0; a design that mixed up the trigger bits would latch the wrong pins or miss one of the edges. For level-mode pins the bench writes the clear register and expects the status to survive; it also writes zeros to the clear register and expects no change. A design that treated clear as plain write-data, or latched level events, would fail there. Finally the bench checks that `irq` follows the enable register and stays high for exactly one cycle after the clear; a combinational or two-stage interrupt path would miss that cycle.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_DATA   = 4'd0,
    RG_DEN    = 4'd1,
    RG_DIR    = 4'd2,
    RG_PUN    = 4'd3,
    RG_PD     = 4'd4,
    RG_SENSE  = 4'd5,
    RG_BOTH   = 4'd6,
    RG_EVT    = 4'd7,
    RG_IEN    = 4'd8,
    RG_RAW    = 4'd9,
    RG_MASKED = 4'd10,
    RG_CLEAR  = 4'd11
  } gpio_reg_e;

endpackage

// File: rtl/gpio_sense_sync.sv
// Two-flop synchronizer plus one extra stage holding the previous sample.
module gpio_sense_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);

  logic [W-1:0] meta_q, lvl_q, prev_q;
  logic [W-1:0] meta_d, lvl_d, prev_d;

  always_comb begin
    meta_d = pin_in;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = lvl_q;
  assign prev = prev_q;

endmodule

// File: rtl/gpio_sense_detect.sv
// Per-pin event detection and raw status storage.
module gpio_sense_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] both,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw
);

  logic [W-1:0] raw_q, raw_d;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit;
    always_comb begin
      rise = lvl[i] & ~prev[i];
      fall = ~lvl[i] & prev[i];
      if (both[i]) hit = rise | fall;
      else         hit = evt[i] ? rise : fall;
      if (sense[i]) raw_d[i] = evt[i] ? lvl[i] : ~lvl[i];
      else          raw_d[i] = (raw_q[i] & ~clr[i]) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw = raw_q;

endmodule

// File: rtl/gpio_sense_regs.sv
// Register file with read multiplexer and clear pulse generation.
module gpio_sense_regs
  import gpio_sense_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      lvl,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      den_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      pun_q,
  output logic [W-1:0]      pd_q,
  output logic [W-1:0]      sense_q,
  output logic [W-1:0]      both_q,
  output logic [W-1:0]      evt_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      clr_vec
);

  logic [W-1:0] out_d, den_d, dir_d, pun_d, pd_d, sense_d, both_d, evt_d, ien_d;
  logic we_data, we_den, we_dir, we_pun, we_pd, we_sense, we_both, we_evt, we_ien, we_clr;

  always_comb begin
    we_data  = wr_req && (addr == RG_DATA);
    we_den   = wr_req && (addr == RG_DEN);
    we_dir   = wr_req && (addr == RG_DIR);
    we_pun   = wr_req && (addr == RG_PUN);
    we_pd    = wr_req && (addr == RG_PD);
    we_sense = wr_req && (addr == RG_SENSE);
    we_both  = wr_req && (addr == RG_BOTH);
    we_evt   = wr_req && (addr == RG_EVT);
    we_ien   = wr_req && (addr == RG_IEN);
    we_clr   = wr_req && (addr == RG_CLEAR);

    out_d   = we_data  ? ((out_q & ~den_q) | (wdata & den_q)) : out_q;
    den_d   = we_den   ? wdata : den_q;
    dir_d   = we_dir   ? wdata : dir_q;
    pun_d   = we_pun   ? wdata : pun_q;
    pd_d    = we_pd    ? wdata : pd_q;
    sense_d = we_sense ? wdata : sense_q;
    both_d  = we_both  ? wdata : both_q;
    evt_d   = we_evt   ? wdata : evt_q;
    ien_d   = we_ien   ? wdata : ien_q;
    clr_vec = we_clr   ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      den_q   <= '0;
      dir_q   <= '0;
      pun_q   <= '1;
      pd_q    <= '0;
      sense_q <= '0;
      both_q  <= '0;
      evt_q   <= '0;
      ien_q   <= '0;
    end else begin
      out_q   <= out_d;
      den_q   <= den_d;
      dir_q   <= dir_d;
      pun_q   <= pun_d;
      pd_q    <= pd_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      evt_q   <= evt_d;
      ien_q   <= ien_d;
    end
  end

  always_comb begin
    unique case (addr)
      RG_DATA:   rdata = lvl & den_q;
      RG_DEN:    rdata = den_q;
      RG_DIR:    rdata = dir_q;
      RG_PUN:    rdata = pun_q;
      RG_PD:     rdata = pd_q;
      RG_SENSE:  rdata = sense_q;
      RG_BOTH:   rdata = both_q;
      RG_EVT:    rdata = evt_q;
      RG_IEN:    rdata = ien_q;
      RG_RAW:    rdata = raw;
      RG_MASKED: rdata = raw & ien_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
  import gpio_sense_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pull_up_n,
  output logic [W-1:0]      pull_dn,
  output logic              irq
);

  logic [W-1:0] lvl, prev, raw_q;
  logic [W-1:0] out_q, den_q, dir_q, pun_q, pd_q, sense_q, both_q, evt_q, ien_q, clr_vec;
  logic         wr_req;
  logic         irq_q, irq_d;

  assign wr_req = bus_valid & bus_write;

  gpio_sense_sync #(.W(W)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .lvl    (lvl),
    .prev   (prev)
  );

  gpio_sense_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .lvl     (lvl),
    .raw     (raw_q),
    .rdata   (bus_rdata),
    .out_q   (out_q),
    .den_q   (den_q),
    .dir_q   (dir_q),
    .pun_q   (pun_q),
    .pd_q    (pd_q),
    .sense_q (sense_q),
    .both_q  (both_q),
    .evt_q   (evt_q),
    .ien_q   (ien_q),
    .clr_vec (clr_vec)
  );

  gpio_sense_detect #(.W(W)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .prev  (prev),
    .sense (sense_q),
    .both  (both_q),
    .evt   (evt_q),
    .clr   (clr_vec),
    .raw   (raw_q)
  );

  always_comb irq_d = |(raw_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign pin_out   = out_q;
  assign pin_oe    = dir_q;
  assign pull_up_n = pun_q;
  assign pull_dn   = pd_q;
  assign irq       = irq_q;

endmodule

// File: rtl/gpio_sense_port_chk.sv
module gpio_sense_port_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic [W-1:0] raw,
  input logic [W-1:0] ien,
  input logic [W-1:0] lvl,
  input logic [W-1:0] prev,
  input logic [W-1:0] sense,
  input logic [W-1:0] evt,
  input logic [W-1:0] clr
);

  // R8
  irq_follows_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(raw & ien)));

  for (genvar i = 0; i < W; i++) begin : g_bit
    // R5
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[i] && !sense[i] && !clr[i]) |=> raw[i]);
    // R5
    no_spurious_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw[i] && !sense[i] && (lvl[i] == prev[i])) |=> !raw[i]);
    // R6
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[i] && evt[i]) |=> (raw[i] == $past(lvl[i])));
    // R6
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense[i] && !evt[i]) |=> (raw[i] == !$past(lvl[i])));
  end

endmodule

bind gpio_sense_port gpio_sense_port_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .irq   (irq),
  .raw   (raw_q),
  .ien   (ien_q),
  .lvl   (lvl),
  .prev  (prev),
  .sense (sense_q),
  .evt   (evt_q),
  .clr   (clr_vec)
);

// File: tb/gpio_sense_port_bench.sv
module gpio_sense_port_bench;

  localparam int W = 32;
  localparam logic [3:0] A_DATA = 4'd0, A_DEN = 4'd1, A_DIR = 4'd2, A_PUN = 4'd3,
                         A_PD = 4'd4, A_SENSE = 4'd5, A_BOTH = 4'd6, A_EVT = 4'd7,
                         A_IEN = 4'd8, A_RAW = 4'd9, A_MASKED = 4'd10, A_CLEAR = 4'd11;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_valid, bus_write;
  logic [3:0]   bus_addr;
  logic [W-1:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe, pull_up_n, pull_dn;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  gpio_sense_port u_gpio_sense_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_up_n(pull_up_n),
    .pull_dn(pull_dn), .irq(irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(1);
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [W-1:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    pin_in = v;
    wait_cyc(3);
  endtask

  task automatic t_reset();
    logic [W-1:0] r;
    do_reset();
    chk("R9 pin_out", pin_out, '0);
    chk("R9 pin_oe", pin_oe, '0);
    chk("R9 pull_up_n", pull_up_n, '1);
    chk("R9 pull_dn", pull_dn, '0);
    chk("R9 irq", {31'd0, irq}, '0);
    bus_rd(A_RAW, r);
    chk("R9 raw", r, '0);
  endtask

  task automatic t_dir_pulls();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_DIR, 32'h0000_F0F0);
    chk("R1 pin_oe", pin_oe, 32'h0000_F0F0);
    bus_wr(A_PUN, 32'hFFFF_FFFE);
    chk("R4 pull_up_n", pull_up_n, 32'hFFFF_FFFE);
    bus_wr(A_PD, 32'h0000_0002);
    chk("R4 pull_dn", pull_dn, 32'h0000_0002);
    bus_rd(A_PUN, r);
    chk("R4 pull-up readback", r, 32'hFFFF_FFFE);
  endtask

  task automatic t_data();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_DEN, 32'h0000_00FF);
    bus_wr(A_DATA, 32'hFFFF_FFFF);
    chk("R2 masked write low byte", pin_out, 32'h0000_00FF);
    bus_wr(A_DEN, 32'h0000_FF00);
    bus_wr(A_DATA, 32'h0000_0000);
    chk("R2 protected bits kept", pin_out, 32'h0000_00FF);
    bus_wr(A_DATA, 32'h1234_AB00);
    chk("R2 enabled bits written", pin_out, 32'h0000_ABFF);
    pin_in = 32'h1234_5678;
    wait_cyc(1);
    bus_rd(A_DATA, r);
    chk("R3 read before sync done", r, 32'h0000_0000);
    wait_cyc(1);
    bus_rd(A_DATA, r);
    chk("R3 read masked pins", r, 32'h0000_5600);
  endtask

  task automatic t_edge();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_EVT, 32'h0000_0008);          // bit3 rising, bit5 falling
    pin_in = 32'h0000_0028;
    wait_cyc(2);
    bus_rd(A_RAW, r);
    chk("R5 rise not yet latched", r, 32'h0);
    wait_cyc(1);
    bus_rd(A_RAW, r);
    chk("R5 rising edge only bit3", r, 32'h0000_0008);
    set_pins(32'h0);
    bus_rd(A_RAW, r);
    chk("R5 falling edge bit5, bit3 sticky", r, 32'h0000_0028);
    bus_wr(A_CLEAR, 32'h0000_0008);
    bus_rd(A_RAW, r);
    chk("R7 clear bit3", r, 32'h0000_0020);
    bus_wr(A_CLEAR, 32'h0);
    bus_rd(A_RAW, r);
    chk("R7 zero clear no effect", r, 32'h0000_0020);
    bus_rd(A_CLEAR, r);
    chk("R7 clear reads zero", r, 32'h0);
  endtask

  task automatic t_both();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_BOTH, 32'h0000_0080);
    set_pins(32'h0000_0080);
    bus_rd(A_RAW, r);
    chk("R5 both-edge rise", r, 32'h0000_0080);
    bus_wr(A_CLEAR, 32'hFFFF_FFFF);
    bus_rd(A_RAW, r);
    chk("R7 clear all", r, 32'h0);
    set_pins(32'h0);
    bus_rd(A_RAW, r);
    chk("R5 both-edge fall with event 0", r, 32'h0000_0080);
  endtask

  task automatic t_level();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_EVT, 32'h0000_0001);          // bit0 high level, bit1 low level
    bus_wr(A_SENSE, 32'h0000_0003);
    wait_cyc(1);
    bus_rd(A_RAW, r);
    chk("R6 low-level pin active", r, 32'h0000_0002);
    bus_wr(A_CLEAR, 32'h0000_0003);
    bus_rd(A_RAW, r);
    chk("R6 clear ignored while level holds", r, 32'h0000_0002);
    set_pins(32'h0000_0003);
    bus_rd(A_RAW, r);
    chk("R6 high-level pin active", r, 32'h0000_0001);
    set_pins(32'h0);
    bus_rd(A_RAW, r);
    chk("R6 level status follows pin", r, 32'h0000_0002);
  endtask

  task automatic t_irq();
    logic [W-1:0] r;
    do_reset();
    bus_wr(A_EVT, 32'h0000_0004);
    set_pins(32'h0000_0004);
    wait_cyc(1);
    chk("R8 irq low while disabled", {31'd0, irq}, 32'h0);
    bus_rd(A_MASKED, r);
    chk("R8 masked zero while disabled", r, 32'h0);
    bus_wr(A_IEN, 32'h0000_0004);
    bus_rd(A_MASKED, r);
    chk("R8 masked status", r, 32'h0000_0004);
    chk("R8 irq one cycle late", {31'd0, irq}, 32'h0);
    wait_cyc(1);
    chk("R8 irq raised", {31'd0, irq}, 32'h1);
    bus_wr(A_CLEAR, 32'h0000_0004);
    chk("R8 irq held one cycle after clear", {31'd0, irq}, 32'h1);
    wait_cyc(1);
    chk("R8 irq dropped", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; pin_in = '0;
    t_reset();
    t_dir_pulls();
    t_data();
    t_edge();
    t_both();
    t_level();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule